// File: doc/BRIEF.md
# DDR Output Serializer with Per-Bit Tristate

This block turns a parallel word into a double-data-rate serial stream. A word of `W` data bits and a companion word of `W` float-control bits are both captured on the rising edge of a slow word clock. Each word is then sent one bit per half-period of a fast clock. The fast clock runs at `W/2` times the word clock and is phase-aligned to it, so the default `W = 4` gives a 4:1 ratio with a 2:1 clock relation.

The float-control word goes through a second serialization lane built exactly like the data lane. Each control bit therefore leaves in the same half-cycle slot as the data bit with the same index. A control bit of 0 lets the slot drive the pad. A control bit of 1 leaves the pad in high impedance for that slot. The serial data and serial float outputs are exposed, and they also feed a tristate buffer model that drives the `pad` output.

A new word is expected on every word-clock period. Reset is synchronous and active high. It must be held for at least one full word-clock period so that both clock domains see it.

Top module: `ddr_tri_serializer`

## Requirements
- R1: After any `clk_fast` rising edge at which `rst` is high, `ser_data` is 0 in both half-cycles, `ser_float` is 1 in both half-cycles, and `pad` is undriven. The first word after reset leaves idle slots (data 0, float 1) ahead of it.
- R2: `data_word` is sampled at the `clk_word` rising edge. Bit 0 appears on `ser_data` during the high phase that starts at the next `clk_fast` rising edge, which is one fast-clock cycle of latency. Bit 1 follows in the next low phase, then bit 2 in the next high phase, then bit 3 in the next low phase.
- R3: `float_word` is serialized with the same slot order and the same latency as `data_word`. In every slot, `ser_float` equals the float bit with the same index and from the same word as the data bit on `ser_data`.
- R4: `pad` equals `ser_data` in a slot where `ser_float` is 0, and is high impedance in a slot where `ser_float` is 1.
- R5: Words captured on consecutive `clk_word` periods give an unbroken stream, with no gap slot and no repeated slot between the last bit of one word and the first bit of the next.
- R6: Floating a slot does not alter the data lane. With data bits {1,0,1,1} (index 0 first) and float bits {0,0,1,0}, only the third slot floats. A following word with all float bits 1 floats all four of its slots while `ser_data` still carries its bits.
- R7: Changes on `data_word` and `float_word` between `clk_word` rising edges have no effect. Only the value present at the edge is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serial clock; both of its phases carry one slot each |
| clk_word | input | 1 | Word clock, `clk_fast` divided by `W/2`, rising edges aligned |
| rst | input | 1 | Synchronous active-high reset, held at least one word period |
| data_word | input | W | Parallel data; bit 0 is sent first |
| float_word | input | W | Parallel float control; bit n governs the slot of data bit n (1 = high impedance) |
| ser_data | output | 1 | Serial data stream |
| ser_float | output | 1 | Serial float-enable stream, aligned with `ser_data` |
| pad | output | 1 | Tristate buffer model output: `ser_data` or high impedance |

## Verification
The bench samples the middle of every high and low phase and compares all three outputs with a slot queue fed from the words it drove. This catches a design that swaps the rising and falling slots, sends bit 3 first, or adds a cycle of delay, because each of these shifts or permutes random bits away from their expected slots. A float lane whose latency differs from the data lane by even one half-cycle shows up as float bits paired with the wrong data bits. The pad is pulled high in the bench, so a pad that drives a 0 during a floated slot is caught. Glitching the inputs between word edges exposes a design that captures on the wrong clock. A reset applied in mid-stream exposes shift registers that keep stale bits.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;
  // Two slots leave per fast-clock period: one in the high phase, one in the low phase.
  localparam int SLOTS_PER_CLK = 2;

  typedef struct packed {
    logic fall;
    logic rise;
  } slot_pair_t;
endpackage

// File: rtl/ddr_frame_ctrl.sv
module ddr_frame_ctrl (
  input  logic clk_fast,
  input  logic clk_word,
  input  logic rst,
  output logic load
);
  // Word-clock domain toggles once per captured word.
  logic word_tog_q;
  // Fast-clock domain copy; a mismatch marks the first fast cycle of a new frame.
  logic seen_tog_q;

  always_ff @(posedge clk_word) begin
    if (rst) word_tog_q <= 1'b0;
    else     word_tog_q <= ~word_tog_q;
  end

  always_ff @(posedge clk_fast) begin
    if (rst) seen_tog_q <= 1'b0;
    else     seen_tog_q <= word_tog_q;
  end

  assign load = word_tog_q ^ seen_tog_q;

  // R5: a frame spans at least two fast cycles, so two loads never touch.
  assert_load_spacing_R5: assert property (@(posedge clk_fast) disable iff (rst)
    load |=> !load);
endmodule

// File: rtl/ddr_lane.sv
module ddr_lane
  import ddr_ser_pkg::*;
#(
  parameter int   W       = 4,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk_fast,
  input  logic         clk_word,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] par_i,
  output slot_pair_t   pair_o
);
  localparam int SW = SLOTS_PER_CLK;

  logic [W-1:0] hold_q;
  logic [W-1:0] shf_q;
  slot_pair_t   pair_q;

  // Capture on the word clock.
  always_ff @(posedge clk_word) begin
    if (rst) hold_q <= {W{RST_VAL}};
    else     hold_q <= par_i;
  end

  // Fast-clock shifter: two bits leave per cycle, lowest index first.
  always_ff @(posedge clk_fast) begin
    if (rst) begin
      shf_q       <= {W{RST_VAL}};
      pair_q.rise <= RST_VAL;
      pair_q.fall <= RST_VAL;
    end else if (load) begin
      pair_q.rise <= hold_q[0];
      pair_q.fall <= hold_q[1];
      shf_q       <= {{SW{RST_VAL}}, hold_q[W-1:SW]};
    end else begin
      pair_q.rise <= shf_q[0];
      pair_q.fall <= shf_q[1];
      shf_q       <= {{SW{RST_VAL}}, shf_q[W-1:SW]};
    end
  end

  assign pair_o = pair_q;

  // R1: reset leaves the lane at its idle level in both slots.
  assert_lane_idle_R1: assert property (@(posedge clk_fast)
    rst |=> (pair_q.rise == RST_VAL && pair_q.fall == RST_VAL));

  // R2 (data lane) and R3 (float lane): the first two bits follow one cycle after load.
  assert_first_pair_R2: assert property (@(posedge clk_fast) disable iff (rst)
    load |=> (pair_q.rise == $past(hold_q[0]) && pair_q.fall == $past(hold_q[1])));

  // R2/R3: the upper bits of the same word come in the following cycle.
  assert_second_pair_R2: assert property (@(posedge clk_fast) disable iff (rst)
    load |=> ##1 (pair_q.rise == $past(hold_q[2], 2) && pair_q.fall == $past(hold_q[3], 2)));
endmodule

// File: rtl/ddr_out_stage.sv
module ddr_out_stage
  import ddr_ser_pkg::*;
(
  input  logic       clk_fast,
  input  slot_pair_t dat_pair,
  input  slot_pair_t flt_pair,
  output logic       ser_data,
  output logic       ser_float,
  output logic       pad
);
  // The clock level picks the slot: high phase carries rise, low phase carries fall.
  assign ser_data  = clk_fast ? dat_pair.rise : dat_pair.fall;
  assign ser_float = clk_fast ? flt_pair.rise : flt_pair.fall;

  // Tristate buffer model.
  assign pad = ser_float ? 1'bz : ser_data;
endmodule

// File: rtl/ddr_tri_serializer.sv
module ddr_tri_serializer
  import ddr_ser_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_fast,
  input  logic         clk_word,
  input  logic         rst,
  input  logic [W-1:0] data_word,
  input  logic [W-1:0] float_word,
  output logic         ser_data,
  output logic         ser_float,
  output logic         pad
);
  localparam int   LANES    = 2;
  localparam logic [LANES-1:0] LANE_IDLE = 2'b10; // lane 0 data idles 0, lane 1 float idles 1

  logic                        load;
  logic [LANES-1:0][W-1:0]     words;
  slot_pair_t [LANES-1:0]      pairs;

  assign words[0] = data_word;
  assign words[1] = float_word;

  ddr_frame_ctrl u_frame (
    .clk_fast (clk_fast),
    .clk_word (clk_word),
    .rst      (rst),
    .load     (load)
  );

  // Identical lanes give the data and float paths matched latency.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ddr_lane #(
      .W       (W),
      .RST_VAL (LANE_IDLE[g])
    ) u_lane (
      .clk_fast (clk_fast),
      .clk_word (clk_word),
      .rst      (rst),
      .load     (load),
      .par_i    (words[g]),
      .pair_o   (pairs[g])
    );
  end

  ddr_out_stage u_out (
    .clk_fast  (clk_fast),
    .dat_pair  (pairs[0]),
    .flt_pair  (pairs[1]),
    .ser_data  (ser_data),
    .ser_float (ser_float),
    .pad       (pad)
  );

  // R1: the port pair goes idle after a reset edge.
  assert_port_idle_R1: assert property (@(posedge clk_fast)
    rst |=> (ser_float && !ser_data));
endmodule

// File: tb/test_ddr_tri_serializer.sv
module test_ddr_tri_serializer;
  localparam int W = 4;

  logic         clk_fast, clk_word, rst;
  logic [W-1:0] data_word, float_word;
  logic         ser_data, ser_float;
  wire          pad_w;

  pullup (pad_w);

  ddr_tri_serializer #(.W(W)) i_ddr_tri_serializer (
    .clk_fast   (clk_fast),
    .clk_word   (clk_word),
    .rst        (rst),
    .data_word  (data_word),
    .float_word (float_word),
    .ser_data   (ser_data),
    .ser_float  (ser_float),
    .pad        (pad_w)
  );

  // 50 MHz fast clock; word clock toggles on each fast rising edge.
  initial begin
    clk_fast = 0;
    clk_word = 0;
    forever begin
      #10;
      clk_fast = ~clk_fast;
      if (clk_fast) clk_word = ~clk_word;
    end
  end

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string phase    = "R2";

  // Reference: queue of {float, data} slots, two popped per fast cycle.
  logic [1:0] slot_q[$];
  logic [1:0] exp_hi, exp_lo;
  localparam logic [1:0] IDLE = 2'b10;

  always @(posedge clk_fast) begin
    if (rst) begin
      slot_q.delete();
      exp_hi = IDLE;
      exp_lo = IDLE;
    end else begin
      if (slot_q.size() >= 2) begin
        exp_hi = slot_q.pop_front();
        exp_lo = slot_q.pop_front();
      end else begin
        exp_hi = IDLE;
        exp_lo = IDLE;
      end
      if (clk_word)
        for (int i = 0; i < W; i++) slot_q.push_back({float_word[i], data_word[i]});
    end
  end

  task automatic check_slot(input logic [1:0] e, input bit in_rst);
    logic exp_pad;
    string tag_d, tag_f;
    exp_pad = e[1] ? 1'b1 : e[0];
    tag_d = in_rst ? "R1" : "R2";
    tag_f = in_rst ? "R1" : "R3";
    n_checks++;
    if (ser_data !== e[0]) begin
      n_fail++;
      $display("FAIL %s/%s ser_data actual=%b expected=%b t=%0t", tag_d, phase, ser_data, e[0], $time);
    end
    n_checks++;
    if (ser_float !== e[1]) begin
      n_fail++;
      $display("FAIL %s/%s ser_float actual=%b expected=%b t=%0t", tag_f, phase, ser_float, e[1], $time);
    end
    n_checks++;
    if (pad_w !== exp_pad) begin
      n_fail++;
      $display("FAIL R4/%s pad actual=%b expected=%b t=%0t", phase, pad_w, exp_pad, $time);
    end
  endtask

  // Sample mid high phase and mid low phase.
  always @(posedge clk_fast) begin
    bit r;
    r = rst;
    #5;  if (!done) check_slot(exp_hi, r);
    #10; if (!done) check_slot(exp_lo, r);
  end

  task automatic drive_word(input logic [W-1:0] d, input logic [W-1:0] t);
    @(posedge clk_word);
    #15;
    data_word  = d;
    float_word = t;
  endtask

  // R7: garbage between edges, final value set just before the edge.
  task automatic drive_noisy(input logic [W-1:0] d, input logic [W-1:0] t);
    @(posedge clk_word);
    #5;  data_word = W'($urandom); float_word = W'($urandom);
    #20; data_word = W'($urandom); float_word = W'($urandom);
    #10; data_word = d; float_word = t;
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst        = 1;
    data_word  = '0;
    float_word = '1;
    repeat (3) @(posedge clk_word);
    #15;
    phase = "R1";
    repeat (2) @(posedge clk_word);
    #15;
    rst = 0;

    // R2/R3: random back-to-back words.
    phase = "R2";
    for (int k = 0; k < 40; k++) drive_word(W'($urandom), W'($urandom));

    // R6: data 1,0,1,1 with float 0,0,1,0, then all-float word.
    phase = "R6";
    drive_word(4'b1101, 4'b0100);
    drive_word(4'b0110, 4'b1111);
    drive_word(4'b0001, 4'b0000);

    // R5: alternating extremes back to back.
    phase = "R5";
    for (int k = 0; k < 16; k++)
      drive_word((k % 2) ? 4'b0000 : 4'b1111, (k % 3 == 0) ? 4'b1010 : 4'b0000);

    // R7: inputs glitch between word edges.
    phase = "R7";
    for (int k = 0; k < 30; k++) drive_noisy(W'($urandom), W'($urandom));

    // R1: reset mid-stream, then resume.
    phase = "R1";
    @(posedge clk_word);
    #15;
    rst = 1;
    repeat (2) @(posedge clk_word);
    #15;
    rst = 0;
    phase = "R3";
    for (int k = 0; k < 30; k++) drive_word(W'($urandom), W'($urandom));

    repeat (4) @(posedge clk_word);
    #2;
    finish_run();
  end
endmodule